// File: doc/BRIEF.md
# Multi-Channel Edge-Programmed PWM Generator

This block produces up to sixteen pulse-width-modulated outputs that all run from one shared timebase. A prescaler divides the input clock into ticks, and a step counter counts those ticks to form the waveform period. Each channel has two programmed step positions. The output goes high at the first position and low at the second, and the high interval wraps across the period boundary when the first position is the later of the two.

Software writes settings over a byte-wide register port into shadow copies. A sync strobe asks for those shadow values to be committed. The commit happens at the next period boundary, so the period length and all edge positions change together and no truncated or mixed period appears on any output. Channel enables are not shadowed: clearing an enable bit forces that channel low at once. Reading a register returns its shadow value.

Top module: `pwm_multi_edge`

## Requirements
- R1: After synchronous reset, every output is low and every register reads back as 0. The active prescale and step limit are both 0.
- R2: The output period is (P+1)·(S+1) input clocks. P is the active prescale and S is the active step limit.
- R3: When the rise position Ra is less than the fall position Fa, the output is high for (Fa−Ra)·(P+1) clocks in each period.
- R4: When Ra is greater than Fa, the high interval wraps across the period boundary and lasts (S+1−Ra+Fa)·(P+1) clocks in each period.
- R5: When Ra equals Fa, an enabled channel stays low.
- R6: With S=0xFE, Ra=0 and Fa=0xFF, the output is high on every clock. With S=0xFF and the same positions, it is high for 255 of every 256 steps.
- R7: Writes to prescale, step limit, rise and fall registers change the shadow copy only. The waveform is unchanged until a sync strobe is issued, which means writing a value with bit 0 set to address 0x04.
- R8: A sync request is committed at the next period boundary and then clears itself. Shadow writes made after the commit have no effect until another sync strobe is issued.
- R9: Enable bits live at address 0x02, where bit n enables channel n, and at address 0x03, where bit n enables channel 8+n. A disabled channel's output is low from the second clock after the write, with no wait for a period boundary.
- R10: The register map is: prescale at 0x00, step limit at 0x01, rise position of channel c at 0x20+c, fall position of channel c at 0x30+c. The read data is registered and shows the shadow value one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data (shadow values) |
| pwm_out | output | NUM_CH (16) | Registered channel outputs |

## Verification
The assertions assume that software programs rise and fall positions no larger than the step limit plus one. They also assume the active settings change only on a boundary cycle, and that write strobes last a single clock with stable address and data. The stimulus keeps every position inside the programmed period and drives each write for exactly one cycle between falling edges. After every sync strobe it waits at least one full old period before measuring, so no expectation depends on which part of a period the strobe landed in.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int REG_W   = 8;
  localparam int ADR_W   = 6;
  localparam int MAX_CH  = 16;

  localparam logic [ADR_W-1:0] A_PRESCALE = 6'h00;
  localparam logic [ADR_W-1:0] A_STEPLIM  = 6'h01;
  localparam logic [ADR_W-1:0] A_EN_LO    = 6'h02;
  localparam logic [ADR_W-1:0] A_EN_HI    = 6'h03;
  localparam logic [ADR_W-1:0] A_SYNC     = 6'h04;
  localparam logic [1:0]       PG_RISE    = 2'b10;
  localparam logic [1:0]       PG_FALL    = 2'b11;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DW = pwm_pkg::REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] act_pre,
  input  logic [DW-1:0] act_lim,
  output logic [DW-1:0] step_cnt,
  output logic          wrap
);
  logic [DW-1:0] pre_cnt;
  logic          tick;

  assign tick = (pre_cnt == act_pre);
  assign wrap = tick && (step_cnt == act_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (wrap) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (tick) begin
      pre_cnt  <= '0;
      step_cnt <= step_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= act_pre); // R2
  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    step_cnt <= act_lim); // R2
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int NUM_CH = pwm_pkg::MAX_CH,
  parameter int DW     = pwm_pkg::REG_W,
  parameter int AW     = pwm_pkg::ADR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     wrap,
  output logic [DW-1:0]            rdata,
  output logic [DW-1:0]            act_pre,
  output logic [DW-1:0]            act_lim,
  output logic [NUM_CH-1:0][DW-1:0] act_rise,
  output logic [NUM_CH-1:0][DW-1:0] act_fall,
  output logic [NUM_CH-1:0]        chan_en
);
  import pwm_pkg::*;

  localparam int EN_W = 2 * DW;

  logic [DW-1:0]             sh_pre, sh_lim;
  logic [NUM_CH-1:0][DW-1:0] sh_rise, sh_fall;
  logic [EN_W-1:0]           en_q;
  logic                      pending;
  logic                      sync_wr;
  logic                      commit;
  logic [3:0]                idx;
  logic [DW-1:0]             rd_mux;

  assign sync_wr = wr_en && (addr == A_SYNC) && wdata[0];
  assign commit  = wrap && pending;
  assign idx     = addr[3:0];
  assign chan_en = en_q[NUM_CH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_pre <= '0;
      sh_lim <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PRESCALE: sh_pre <= wdata;
        A_STEPLIM:  sh_lim <= wdata;
        A_EN_LO:    en_q[DW-1:0] <= wdata;
        A_EN_HI:    en_q[EN_W-1:DW] <= wdata;
        default: ;
      endcase
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chreg
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_rise[c]  <= '0;
          sh_fall[c]  <= '0;
          act_rise[c] <= '0;
          act_fall[c] <= '0;
        end else begin
          if (wr_en && addr[5:4] == PG_RISE && idx == 4'(c)) sh_rise[c] <= wdata;
          if (wr_en && addr[5:4] == PG_FALL && idx == 4'(c)) sh_fall[c] <= wdata;
          if (commit) begin
            act_rise[c] <= sh_rise[c];
            act_fall[c] <= sh_fall[c];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre <= '0;
      act_lim <= '0;
      pending <= 1'b0;
    end else begin
      if (commit) begin
        act_pre <= sh_pre;
        act_lim <= sh_lim;
      end
      if (sync_wr)   pending <= 1'b1;
      else if (wrap) pending <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_PRESCALE: rd_mux = sh_pre;
      A_STEPLIM:  rd_mux = sh_lim;
      A_EN_LO:    rd_mux = en_q[DW-1:0];
      A_EN_HI:    rd_mux = en_q[EN_W-1:DW];
      default: begin
        for (int k = 0; k < NUM_CH; k++) begin
          if (idx == 4'(k) && addr[5:4] == PG_RISE) rd_mux = sh_rise[k];
          if (idx == 4'(k) && addr[5:4] == PG_FALL) rd_mux = sh_fall[k];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(act_pre) && $stable(act_lim))); // R7
  AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pending && wrap && !sync_wr) |=> !pending); // R8
  AST_NO_COMMIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pending |=> ($stable(act_pre) && $stable(act_lim))); // R8
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DW = pwm_pkg::REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] rise,
  input  logic [DW-1:0] fall,
  output logic          out_q
);
  logic in_fwd, in_wrap, level;

  always_comb begin
    in_fwd  = (step >= rise) && (step < fall);
    in_wrap = (step >= rise) || (step < fall);
    if (!en)              level = 1'b0;
    else if (rise < fall) level = in_fwd;
    else if (rise > fall) level = in_wrap;
    else                  level = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= level;
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_q); // R9
  AST_EQUAL_LOW: assert property (@(posedge clk) disable iff (rst)
    (rise == fall) |=> !out_q); // R5
endmodule

// File: rtl/pwm_multi_edge.sv
module pwm_multi_edge #(
  parameter int NUM_CH = 16,
  parameter int DW     = pwm_pkg::REG_W,
  parameter int AW     = pwm_pkg::ADR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [DW-1:0]             act_pre, act_lim, step_cnt;
  logic [NUM_CH-1:0][DW-1:0] act_rise, act_fall;
  logic [NUM_CH-1:0]         chan_en;
  logic                      wrap;

  pwm_regs #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wrap(wrap), .rdata(rdata), .act_pre(act_pre), .act_lim(act_lim),
    .act_rise(act_rise), .act_fall(act_fall), .chan_en(chan_en)
  );

  pwm_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst(rst), .act_pre(act_pre), .act_lim(act_lim),
    .step_cnt(step_cnt), .wrap(wrap)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_channel #(.DW(DW)) u_ch (
        .clk(clk), .rst(rst), .en(chan_en[c]), .step(step_cnt),
        .rise(act_rise[c]), .fall(act_fall[c]), .out_q(pwm_out[c])
      );
    end
  endgenerate

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (pwm_out == '0)); // R1
endmodule

// File: tb/tb_pwm_multi_edge.sv
module tb_pwm_multi_edge;
  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [5:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic [NCH-1:0] pwm_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pwm_multi_edge #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  typedef struct {
    bit    konst;
    int    ch;
    int    len;
    int    high;
    string req;
  } exp_t;

  exp_t q[$];
  int   done_cnt = 0;

  task automatic report(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [5:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    report(rdata == e, req, int'(rdata), int'(e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver side: push expected item, wait for the monitor to retire it
  task automatic expect_wave(input int ch, input int per, input int hi, input string req);
    int target;
    exp_t e;
    e.konst = 0; e.ch = ch; e.len = per; e.high = hi; e.req = req;
    target = done_cnt + 1;
    q.push_back(e);
    wait (done_cnt == target);
  endtask

  task automatic expect_const(input int ch, input int n, input int hi, input string req);
    int target;
    exp_t e;
    e.konst = 1; e.ch = ch; e.len = n; e.high = hi; e.req = req;
    target = done_cnt + 1;
    q.push_back(e);
    wait (done_cnt == target);
  endtask

  // monitor: measures outputs at falling edges and compares
  initial begin
    exp_t it;
    forever begin
      wait (q.size() > 0);
      it = q[0];
      if (it.konst) begin
        int hi;
        hi = 0;
        for (int i = 0; i < it.len; i++) begin
          @(negedge clk);
          if (pwm_out[it.ch]) hi++;
        end
        report(hi == it.high, it.req, hi, it.high);
      end else begin
        bit prev;
        int cnt, hi;
        prev = pwm_out[it.ch];
        forever begin
          @(negedge clk);
          if (pwm_out[it.ch] && !prev) break;
          prev = pwm_out[it.ch];
        end
        cnt = 1; hi = 1; prev = 1'b1;
        forever begin
          @(negedge clk);
          if (pwm_out[it.ch] && !prev) break;
          prev = pwm_out[it.ch];
          cnt++;
          if (pwm_out[it.ch]) hi++;
        end
        report(cnt == it.len, {it.req, " period"}, cnt, it.len);
        report(hi == it.high, {it.req, " high"}, hi, it.high);
      end
      void'(q.pop_front());
      done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    report(pwm_out == '0, "R1 outputs", int'(pwm_out), 0);
    rd_check(6'h00, 8'h00, "R1 prescale");
    rd_check(6'h01, 8'h00, "R1 step limit");
    rd_check(6'h20, 8'h00, "R1 rise ch0");

    // program: P=1, S=9 -> period 20 clocks
    wr(6'h00, 8'd1);
    wr(6'h01, 8'd9);
    wr(6'h20, 8'd2); wr(6'h30, 8'd5);   // ch0 forward
    wr(6'h21, 8'd7); wr(6'h31, 8'd3);   // ch1 wrap
    wr(6'h22, 8'd4); wr(6'h32, 8'd4);   // ch2 equal
    wr(6'h02, 8'h0F);
    // R10 readback of shadow values
    rd_check(6'h01, 8'd9, "R10 step limit");
    rd_check(6'h21, 8'd7, "R10 rise ch1");
    rd_check(6'h32, 8'd4, "R10 fall ch2");
    rd_check(6'h02, 8'h0F, "R10 enable low");
    // R7: no sync yet -> ch0 still idle-low
    expect_const(0, 40, 0, "R7 no sync");
    wr(6'h04, 8'h01);
    idle(30);
    expect_wave(0, 20, 6, "R2 R3 ch0");
    expect_wave(1, 20, 12, "R4 ch1 wrap");
    expect_const(2, 60, 0, "R5 equal");

    // R7: shadow change without sync keeps old period
    wr(6'h01, 8'd4);
    rd_check(6'h01, 8'd4, "R10 shadow readback");
    idle(45);
    expect_wave(0, 20, 6, "R7 unsynced");
    // R8: sync commits at boundary, then clears
    wr(6'h04, 8'h01);
    idle(25);
    expect_wave(0, 10, 6, "R8 committed");
    wr(6'h01, 8'd9);
    idle(45);
    expect_wave(0, 10, 6, "R8 pending cleared");

    // R9: disable channel 0 immediately
    wr(6'h02, 8'h0E);
    idle(1);
    expect_const(0, 30, 0, "R9 disable low");
    // R9: high-byte enable for channel 9
    wr(6'h29, 8'd0); wr(6'h39, 8'd2);
    wr(6'h01, 8'd4);
    wr(6'h03, 8'h02);
    wr(6'h04, 8'h01);
    idle(25);
    expect_wave(9, 10, 4, "R9 channel 9");

    // R6: full duty with S=0xFE
    wr(6'h00, 8'd0);
    wr(6'h01, 8'hFE);
    wr(6'h23, 8'd0); wr(6'h33, 8'hFF);
    wr(6'h02, 8'h08);
    wr(6'h04, 8'h01);
    idle(30);
    expect_const(3, 300, 300, "R6 full duty");
    // R6: S=0xFF cannot reach full duty
    wr(6'h01, 8'hFF);
    wr(6'h04, 8'h01);
    idle(260);
    expect_wave(3, 256, 255, "R6 limit");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule